// File: doc/BRIEF.md
# Quad Wiper Register Adjust Unit

This block holds the position codes of four digitally set potentiometer wipers, each a 6-bit code. It applies adjustment commands that a serial front end has already decoded. It also accepts a bulk reload of all four codes from a nonvolatile store.

A command carries an operation, a channel address, a broadcast flag and a data byte. The operations are:

- a direct load of a code;
- a one-step raise or lower;
- a doubling or halving of the code, which gives roughly ±6 dB per step for log-taper control.

All arithmetic saturates at the ends of the code range. A write-protect input freezes the codes against every command, but the nonvolatile reload still works while it is asserted. A combinational readback port returns any one channel's code, and the packed vector of all four codes drives the analog side.

Top module: `wiper_adjust_unit`

## Requirements
- R1: After reset every channel holds midscale, code 0x20.
- R2: A write (op 1) loads bits [5:0] of cmd_data_i into the addressed channel. Bits [7:6] are ignored, and cmd_all_i has no effect on a write, so only the addressed channel changes.
- R3: With cmd_all_i low, a command changes only the channel selected by cmd_addr_i (0 to 3); every other channel keeps its code.
- R4: Increment (op 2) adds exactly one and holds at 63. Decrement (op 3) subtracts exactly one and holds at 0. Neither wraps around.
- R5: With cmd_all_i high, increment, decrement, left shift and right shift apply to all four channels in the same cycle.
- R6: Left shift (op 4) doubles the code. A code of 32 or more becomes 63, and a code of 0 becomes 1.
- R7: Right shift (op 5) halves the code, rounding down; 0 stays 0.
- R8: While wp_ni is low, no command changes any channel.
- R9: A pulse on nv_load_i loads every channel k from nv_codes_i[6k+5:6k], whether or not wp_ni is low.
- R10: When nv_load_i and a valid command arrive in the same cycle, the nonvolatile load wins and the command is dropped.
- R11: rd_code_o shows, with no clock delay, the code of the channel selected by rd_addr_i. wipers_o carries channel k at bits [6k+5:6k].
- R12: Op codes 0, 6 and 7 leave all channels unchanged. A command takes effect on the clock edge where cmd_valid_i is high and is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 3 | Operation code |
| cmd_all_i | input | 1 | Broadcast to all channels for step and shift operations |
| cmd_addr_i | input | 2 | Target channel |
| cmd_data_i | input | 8 | Data byte for a write |
| wp_ni | input | 1 | Write protect, active low |
| nv_load_i | input | 1 | Bulk reload strobe from the nonvolatile store |
| nv_codes_i | input | 24 | Stored codes, channel k at [6k+5:6k] |
| rd_addr_i | input | 2 | Readback channel select |
| rd_code_o | output | 6 | Readback code |
| wipers_o | output | 24 | All wiper codes, channel k at [6k+5:6k] |

## Verification
The bench builds the block with its default parameters: four channels, 6-bit codes and an 8-bit data byte. With these values both saturation ends, the shift thresholds at 0 and 32 and the ignored upper data bits are each only a few commands away. The protection and priority cases are also driven there, including a reload that collides with a command and a broadcast issued while write protect is asserted.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_INC   = 3'd2,
    OP_DEC   = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHR   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } wiper_op_e;
endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
  import wiper_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              cmd_valid_i,
  input  wiper_op_e         cmd_op_i,
  input  logic              cmd_all_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              wp_ni,
  input  logic              nv_load_i,
  output logic [NUM_CH-1:0] ch_en_o
);
  logic live;
  logic bcast;

  always_comb begin
    unique case (cmd_op_i)
      OP_WRITE, OP_INC, OP_DEC, OP_SHL, OP_SHR: live = cmd_valid_i & wp_ni & ~nv_load_i;
      default:                                  live = 1'b0;
    endcase
    // broadcast never widens a direct write
    bcast = cmd_all_i & (cmd_op_i != OP_WRITE);
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_en
    assign ch_en_o[k] = live & (bcast | (cmd_addr_i == ADDR_W'(k)));
  end

  always_comb begin
    if (!bcast) p_single_target_r3: assert ($onehot0(ch_en_o));
    if (!wp_ni) p_wp_gate_r8: assert (ch_en_o == '0);
  end
endmodule

// File: rtl/wiper_step_alu.sv
module wiper_step_alu
  import wiper_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int DATA_W = 8
) (
  input  wiper_op_e         op_i,
  input  logic [CODE_W-1:0] cur_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] nxt_o
);
  localparam logic [CODE_W-1:0] MAX = '1;
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  logic unused_hi;
  assign unused_hi = ^data_i;

  always_comb begin
    unique case (op_i)
      OP_WRITE: nxt_o = data_i[CODE_W-1:0];
      OP_INC:   nxt_o = (cur_i == MAX) ? MAX : cur_i + ONE;
      OP_DEC:   nxt_o = (cur_i == '0) ? '0 : cur_i - ONE;
      OP_SHL: begin
        if (cur_i == '0)           nxt_o = ONE;
        else if (cur_i[CODE_W-1])  nxt_o = MAX;
        else                       nxt_o = {cur_i[CODE_W-2:0], 1'b0};
      end
      OP_SHR:   nxt_o = {1'b0, cur_i[CODE_W-1:1]};
      default:  nxt_o = cur_i;
    endcase
  end

  always_comb begin
    if (op_i == OP_SHL) p_shl_grows_r6: assert (nxt_o > cur_i || cur_i == MAX);
  end
endmodule

// File: rtl/wiper_adjust_unit.sv
module wiper_adjust_unit
  import wiper_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 6,
  parameter int DATA_W = 8,
  localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int VEC_W  = NUM_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic              cmd_all_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              wp_ni,
  input  logic              nv_load_i,
  input  logic [VEC_W-1:0]  nv_codes_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CODE_W-1:0] rd_code_o,
  output logic [VEC_W-1:0]  wipers_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX = '1;

  wiper_op_e         op;
  logic [NUM_CH-1:0] ch_en;
  logic [CODE_W-1:0] code_q [NUM_CH];
  logic [CODE_W-1:0] code_d [NUM_CH];

  assign op = wiper_op_e'(cmd_op_i);

  wiper_cmd_decode #(.NUM_CH(NUM_CH)) i_decode (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (op),
    .cmd_all_i   (cmd_all_i),
    .cmd_addr_i  (cmd_addr_i),
    .wp_ni       (wp_ni),
    .nv_load_i   (nv_load_i),
    .ch_en_o     (ch_en)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    wiper_step_alu #(.CODE_W(CODE_W), .DATA_W(DATA_W)) i_alu (
      .op_i   (op),
      .cur_i  (code_q[k]),
      .data_i (cmd_data_i),
      .nxt_o  (code_d[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        code_q[k] <= MID;
      else if (nv_load_i) code_q[k] <= nv_codes_i[k*CODE_W +: CODE_W];
      else if (ch_en[k])  code_q[k] <= code_d[k];
    end

    assign wipers_o[k*CODE_W +: CODE_W] = code_q[k];

    p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!nv_load_i && !ch_en[k]) |=> $stable(code_q[k]));
    p_wp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wp_ni && !nv_load_i) |=> $stable(code_q[k]));
    p_nv_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nv_load_i |=> code_q[k] == $past(nv_codes_i[k*CODE_W +: CODE_W]));
    p_inc_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[k] && op == OP_INC) |=>
      code_q[k] == (($past(code_q[k]) == MAX) ? MAX : $past(code_q[k]) + CODE_W'(1)));
    p_dec_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[k] && op == OP_DEC) |=>
      code_q[k] == (($past(code_q[k]) == '0) ? '0 : $past(code_q[k]) - CODE_W'(1)));
    p_shr_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[k] && op == OP_SHR) |=> code_q[k] == ($past(code_q[k]) >> 1));
  end

  assign rd_code_o = code_q[rd_addr_i];
endmodule

// File: tb/test_wiper_adjust_unit.sv
module test_wiper_adjust_unit;
  localparam int NCH = 4;
  localparam int CW  = 6;
  localparam int VW  = NCH * CW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = '0;
  logic          cmd_all_i = 1'b0;
  logic [1:0]    cmd_addr_i = '0;
  logic [7:0]    cmd_data_i = '0;
  logic          wp_ni = 1'b1;
  logic          nv_load_i = 1'b0;
  logic [VW-1:0] nv_codes_i = '0;
  logic [1:0]    rd_addr_i = '0;
  logic [CW-1:0] rd_code_o;
  logic [VW-1:0] wipers_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [CW-1:0] model [NCH];
  logic [VW-1:0] exp_q [$];
  string         tag_q [$];

  always #5 clk_i = ~clk_i;

  wiper_adjust_unit i_wiper_adjust_unit (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_all_i, .cmd_addr_i,
    .cmd_data_i, .wp_ni, .nv_load_i, .nv_codes_i, .rd_addr_i,
    .rd_code_o, .wipers_o
  );

  function automatic logic [CW-1:0] step(logic [2:0] op, logic [CW-1:0] c, logic [7:0] d);
    case (op)
      3'd1: return d[CW-1:0];
      3'd2: return (c == 63) ? 6'd63 : c + 6'd1;
      3'd3: return (c == 0) ? 6'd0 : c - 6'd1;
      3'd4: return (c == 0) ? 6'd1 : (c >= 32) ? 6'd63 : c * 2;
      3'd5: return c / 2;
      default: return c;
    endcase
  endfunction

  function automatic logic [VW-1:0] pack_model();
    logic [VW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*CW +: CW] = model[k];
    return v;
  endfunction

  task automatic issue(input logic [2:0] op, input logic all, input logic [1:0] addr,
                       input logic [7:0] data, input logic wp, input logic nv,
                       input logic [VW-1:0] nvv, input string tag);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_all_i = all; cmd_addr_i = addr;
    cmd_data_i = data; wp_ni = wp; nv_load_i = nv; nv_codes_i = nvv;
    @(posedge clk_i);
    if (nv) begin
      for (int k = 0; k < NCH; k++) model[k] = nvv[k*CW +: CW];
    end else if (wp) begin
      for (int k = 0; k < NCH; k++)
        if ((all && op != 3'd1) || addr == 2'(k)) model[k] = step(op, model[k], data);
    end
    exp_q.push_back(pack_model());
    tag_q.push_back(tag);
    #1;
    cmd_valid_i = 1'b0; nv_load_i = 1'b0; wp_ni = 1'b1;
  endtask

  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [VW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (wipers_o !== e) begin
        errors++;
        $display("FAIL %s: wipers got %h expected %h", t, wipers_o, e);
      end
    end
  end

  task automatic check_rd(input string tag);
    @(negedge clk_i);
    for (int k = 0; k < NCH; k++) begin
      rd_addr_i = 2'(k);
      #1;
      checks++;
      if (rd_code_o !== model[k]) begin
        errors++;
        $display("FAIL %s: channel %0d got %h expected %h", tag, k, rd_code_o, model[k]);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) model[k] = 6'h20;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check_rd("R1 reset midscale");
    checks++;
    if (wipers_o !== {NCH{6'h20}}) begin
      errors++;
      $display("FAIL R1: wipers got %h expected %h", wipers_o, {NCH{6'h20}});
    end
    issue(3'd1, 1'b0, 2'd1, 8'hE5, 1'b1, 1'b0, '0, "R2 write ignores high bits");
    issue(3'd1, 1'b1, 2'd2, 8'h07, 1'b1, 1'b0, '0, "R2 write ignores broadcast");
    issue(3'd2, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R3 R4 inc one channel");
    issue(3'd1, 1'b0, 2'd3, 8'h3F, 1'b1, 1'b0, '0, "R2 write max");
    issue(3'd2, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, '0, "R4 inc saturates at 63");
    issue(3'd1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R2 write zero");
    issue(3'd3, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R4 dec holds at 0");
    issue(3'd3, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, '0, "R4 dec one step");
    issue(3'd2, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R5 broadcast inc");
    issue(3'd3, 1'b1, 2'd2, 8'h00, 1'b1, 1'b0, '0, "R5 broadcast dec");
    issue(3'd1, 1'b0, 2'd1, 8'h05, 1'b1, 1'b0, '0, "R2 write 5");
    issue(3'd4, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, '0, "R6 shl doubles");
    issue(3'd1, 1'b0, 2'd1, 8'h28, 1'b1, 1'b0, '0, "R2 write 40");
    issue(3'd4, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, '0, "R6 shl saturates");
    issue(3'd1, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, '0, "R2 write 0");
    issue(3'd4, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, '0, "R6 shl of zero gives 1");
    issue(3'd1, 1'b0, 2'd3, 8'h07, 1'b1, 1'b0, '0, "R2 write 7");
    issue(3'd5, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, '0, "R7 shr halves");
    issue(3'd5, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, '0, "R7 shr again");
    issue(3'd5, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R5 R7 broadcast shr");
    issue(3'd4, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, '0, "R5 R6 broadcast shl");
    issue(3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, '0, "R8 protected inc");
    issue(3'd1, 1'b0, 2'd1, 8'h11, 1'b0, 1'b0, '0, "R8 protected write");
    issue(3'd4, 1'b1, 2'd0, 8'h00, 1'b0, 1'b0, '0, "R8 protected broadcast");
    issue(3'd0, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1, {6'd9, 6'd40, 6'd3, 6'd17}, "R9 reload under protect");
    issue(3'd2, 1'b1, 2'd0, 8'h00, 1'b1, 1'b1, {6'd1, 6'd2, 6'd62, 6'd33}, "R10 reload wins");
    issue(3'd6, 1'b1, 2'd0, 8'h3F, 1'b1, 1'b0, '0, "R12 op 6 no effect");
    issue(3'd7, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, '0, "R12 op 7 no effect");
    issue(3'd0, 1'b1, 2'd2, 8'h00, 1'b1, 1'b0, '0, "R12 op 0 no effect");
    issue(3'd1, 1'b0, 2'd2, 8'h15, 1'b1, 1'b0, '0, "R2 write before readback");
    @(negedge clk_i);
    check_rd("R11 readback");
    wait (exp_q.size() == 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule